// File: doc/BRIEF.md
# Multiplexed Address Capture and Cycle Decoder

This block is the control front end of a multiplexed-address memory of 262144 sixteen-bit words. A 9-bit shared address bus carries the row half of the 18-bit location address and then the column half. A falling row strobe opens a cycle and captures the row half. At that same edge the block also captures the levels of the transfer enable, the special-function select, the write enable and both byte column strobes, and these levels fix the class of the cycle. The first falling column strobe then captures the column half and the byte enables. At that point the block issues a single request to downstream logic. A rising row strobe closes the cycle and clears all latched state.

All strobes and controls are active low except the special-function select. They are treated as synchronous signals that are already sampled into the block's clock domain. An edge is a change of level between two consecutive clock samples. The request is registered: it appears one clock after the cycle in which the deciding strobe edge is seen. A row fall that finds both column strobes already low is an option-reset cycle. It is reported at once and needs no column address.

Top module: `cyc_front`

## Requirements
- R1: While rst_n is low, and after it is released with no strobe activity, req_valid_o is 0 and req_kind_o, req_row_o, req_col_o and req_be_o are all 0.
- R2: The value on addr_i in the clock cycle where row_stb_n first reads 0 after reading 1 is reported as req_row_o for that row cycle.
- R3: In the clock cycle where a column strobe first falls while row_stb_n is low, addr_i is taken as the column. One clock later, req_valid_o is 1 for exactly one cycle, with req_col_o equal to that column. Between pulses, all request fields hold their last values.
- R4: Only the first column-strobe fall in a row cycle is captured. A later fall of the other strobe in the same row cycle produces no pulse and leaves req_col_o unchanged.
- R5: If xfer_en_n is 0 at the row fall, the cycle is a transfer. The kind is full transfer (req_kind_o = 4) when func_sel is 0, and split transfer (req_kind_o = 5) when func_sel is 1.
- R6: If xfer_en_n is 1 at the row fall and func_sel is 1, the kind is block write (3). If xfer_en_n is 1, func_sel is 0 and wr_en_n is 0 at the row fall, the kind is masked write (2).
- R7: If xfer_en_n, func_sel and wr_en_n are 1, 0 and 1 at the row fall, wr_en_n in the column-capture cycle sets the kind: normal write (1) when it is 0, read (0) when it is 1.
- R8: A row fall with both col_stb_n bits at 0 is an option-reset cycle. One clock later the block pulses req_valid_o with req_kind_o = 6, req_row_o = row, req_col_o = 0 and req_be_o = 0. Column-strobe falls later in that row cycle produce no pulse.
- R9: req_be_o bit 0 is 1 when col_stb_n[0] (the low-byte strobe, data bits 7:0) is low in the capture cycle. Bit 1 is 1 when col_stb_n[1] (high byte, bits 15:8) is low in that cycle.
- R10: A column-strobe fall while row_stb_n is 1 produces no pulse. Once row_stb_n rises, the next row fall decodes again from the control levels present at that new fall.
- R11: Changes to xfer_en_n, func_sel or wr_en_n after the row fall do not change a kind that was fixed at the row fall (kinds 2 to 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 9 | Shared row/column address bus |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 2 | Column strobes, active low; bit 0 low byte, bit 1 high byte |
| wr_en_n | input | 1 | Write enable, active low |
| xfer_en_n | input | 1 | Register-transfer enable, active low |
| func_sel | input | 1 | Special-function select, active high |
| req_valid_o | output | 1 | One-cycle request pulse |
| req_kind_o | output | 3 | Cycle kind: 0 read, 1 write, 2 masked write, 3 block write, 4 full transfer, 5 split transfer, 6 option reset |
| req_row_o | output | 9 | Captured row address |
| req_col_o | output | 9 | Captured column address |
| req_be_o | output | 2 | Byte enables of the request |

## Verification
The checker looks at every clock for several properties. A request never lasts more than one cycle. A request only follows a cycle in which the row strobe was low. Each row fall loads the row register with the bus value. An option-reset request carries a zero column and zero byte enables, and every other request has at least one byte enabled. The bench scenarios cover what spans a whole row cycle: the decode table of kinds, the choice between read and write at column time, the freezing of a kind against later control changes, ignoring the second strobe and strobes outside a cycle, and the fresh decode after the row strobe rises.

// File: rtl/cyc_front_pkg.sv
// Shared types of the multiplexed address front end.
// Assumes a 3-bit kind code that downstream logic decodes as listed.
package cyc_front_pkg;
    typedef enum logic [2:0] {
        KIND_READ    = 3'd0,
        KIND_WRITE   = 3'd1,
        KIND_MASKED  = 3'd2,
        KIND_BLOCK   = 3'd3,
        KIND_FULL_XF = 3'd4,
        KIND_SPLIT_XF= 3'd5,
        KIND_OPT_RST = 3'd6
    } cyc_kind_e;

    // Class fixed at the row fall; KIND_READ here means "plain access,
    // read or write decided at column time".
    function automatic cyc_kind_e row_class(input logic xfer_n,
                                            input logic fsel,
                                            input logic we_n);
        cyc_kind_e k;
        if (!xfer_n)
            k = fsel ? KIND_SPLIT_XF : KIND_FULL_XF;
        else if (fsel)
            k = KIND_BLOCK;
        else if (!we_n)
            k = KIND_MASKED;
        else
            k = KIND_READ;
        return k;
    endfunction
endpackage

// File: rtl/strobe_edge.sv
// Per-strobe edge detector for already-synchronous active-low strobes.
// Assumes strobes idle high; history resets to high so reset release
// produces no false fall.
module strobe_edge #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] stb_n,
    output logic [WIDTH-1:0] fall,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_n;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Keep last sampled level of strobe i.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_n[i] <= 1'b1;
            else        prev_n[i] <= stb_n[i];
        end
        assign fall[i] = prev_n[i] & ~stb_n[i];
        assign rise[i] = ~prev_n[i] & stb_n[i];
    end
endmodule

// File: rtl/row_stage.sv
// Row stage: captures the row address and fixes the cycle class at the
// row-strobe fall; flags an option-reset start when both column strobes
// are already low. Assumes row_stb_n high closes the cycle.
module row_stage
    import cyc_front_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int NSTB   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_fall,
    input  logic              row_stb_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSTB-1:0]   col_stb_n,
    input  logic              wr_en_n,
    input  logic              xfer_en_n,
    input  logic              func_sel,
    output logic              row_open,
    output logic [ADDR_W-1:0] row_q,
    output cyc_kind_e         cls_q,
    output logic              opt_start
);
    assign opt_start = row_fall & ~(|col_stb_n);

    // Open/close the row cycle and latch row address plus class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            row_q    <= '0;
            cls_q    <= KIND_READ;
        end else if (row_fall) begin
            row_open <= 1'b1;
            row_q    <= addr_i;
            cls_q    <= opt_start ? KIND_OPT_RST
                                  : row_class(xfer_en_n, func_sel, wr_en_n);
        end else if (row_stb_n) begin
            row_open <= 1'b0;
            row_q    <= '0;
            cls_q    <= KIND_READ;
        end
    end
endmodule

// File: rtl/col_stage.sv
// Column stage: produces a single capture strobe on the first column
// strobe fall of an open row cycle; blocks any later capture until the
// row strobe rises. Assumes row_open comes from the row stage.
module col_stage #(
    parameter int NSTB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            row_open,
    input  logic            row_stb_n,
    input  logic            opt_start,
    input  logic [NSTB-1:0] col_fall,
    output logic            cap_now
);
    logic done_q;

    assign cap_now = row_open & ~row_stb_n & ~done_q & (|col_fall);

    // Remember that this row cycle has already been served.
    always_ff @(posedge clk) begin
        if (!rst_n)                  done_q <= 1'b0;
        else if (row_stb_n)          done_q <= 1'b0;
        else if (cap_now | opt_start) done_q <= 1'b1;
    end
endmodule

// File: rtl/cyc_front.sv
// Top of the multiplexed address front end: edge detection, row stage,
// column stage and the registered request. Assumes all strobes are
// synchronous to clk; reset is synchronous and active low.
module cyc_front
    import cyc_front_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int NSTB   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              row_stb_n,
    input  logic [NSTB-1:0]   col_stb_n,
    input  logic              wr_en_n,
    input  logic              xfer_en_n,
    input  logic              func_sel,
    output logic              req_valid_o,
    output logic [2:0]        req_kind_o,
    output logic [ADDR_W-1:0] req_row_o,
    output logic [ADDR_W-1:0] req_col_o,
    output logic [NSTB-1:0]   req_be_o
);
    localparam int NEDGE = NSTB + 1;

    logic [NEDGE-1:0] fall_v, rise_v;
    logic              row_open, opt_start, cap_now;
    logic [ADDR_W-1:0] row_q;
    cyc_kind_e         cls_q, kind_now;

    strobe_edge #(.WIDTH(NEDGE)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .stb_n({col_stb_n, row_stb_n}),
        .fall (fall_v),
        .rise (rise_v)
    );

    row_stage #(.ADDR_W(ADDR_W), .NSTB(NSTB)) u_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_fall (fall_v[0]),
        .row_stb_n(row_stb_n),
        .addr_i   (addr_i),
        .col_stb_n(col_stb_n),
        .wr_en_n  (wr_en_n),
        .xfer_en_n(xfer_en_n),
        .func_sel (func_sel),
        .row_open (row_open),
        .row_q    (row_q),
        .cls_q    (cls_q),
        .opt_start(opt_start)
    );

    col_stage #(.NSTB(NSTB)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_open (row_open),
        .row_stb_n(row_stb_n),
        .opt_start(opt_start),
        .col_fall (fall_v[NEDGE-1:1]),
        .cap_now  (cap_now)
    );

    logic unused_rise;
    assign unused_rise = ^rise_v;

    // Resolve plain access into read or write at column time.
    always_comb begin
        kind_now = cls_q;
        if (cls_q == KIND_READ)
            kind_now = wr_en_n ? KIND_READ : KIND_WRITE;
    end

    // Register the request; pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid_o <= 1'b0;
            req_kind_o  <= '0;
            req_row_o   <= '0;
            req_col_o   <= '0;
            req_be_o    <= '0;
        end else if (opt_start) begin
            req_valid_o <= 1'b1;
            req_kind_o  <= KIND_OPT_RST;
            req_row_o   <= addr_i;
            req_col_o   <= '0;
            req_be_o    <= '0;
        end else if (cap_now) begin
            req_valid_o <= 1'b1;
            req_kind_o  <= kind_now;
            req_row_o   <= row_q;
            req_col_o   <= addr_i;
            req_be_o    <= ~col_stb_n;
        end else begin
            req_valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/cyc_front_chk.sv
// Checker for cyc_front, bound into every instance. Watches ports and the
// row register; assumes synchronous active-low reset.
module cyc_front_chk #(
    parameter int ADDR_W = 9,
    parameter int NSTB   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              row_stb_n,
    input logic              req_valid_o,
    input logic [2:0]        req_kind_o,
    input logic [ADDR_W-1:0] req_col_o,
    input logic [NSTB-1:0]   req_be_o,
    input logic [ADDR_W-1:0] row_q
);
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> !req_valid_o);

    p_row_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_stb_n) |=> (row_q == $past(addr_i)));

    p_row_low_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) |-> !$past(row_stb_n));

    p_optrst_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_kind_o == 3'd6) |-> (req_col_o == '0 && req_be_o == '0));

    p_be_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_kind_o != 3'd6) |-> (req_be_o != '0));
endmodule

bind cyc_front cyc_front_chk #(.ADDR_W(ADDR_W), .NSTB(NSTB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .row_stb_n  (row_stb_n),
    .req_valid_o(req_valid_o),
    .req_kind_o (req_kind_o),
    .req_col_o  (req_col_o),
    .req_be_o   (req_be_o),
    .row_q      (row_q)
);

// File: tb/tb_cyc_front.sv
module tb_cyc_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] addr_i = '0;
    logic       row_stb_n = 1'b1;
    logic [1:0] col_stb_n = 2'b11;
    logic       wr_en_n = 1'b1;
    logic       xfer_en_n = 1'b1;
    logic       func_sel = 1'b0;
    logic       req_valid_o;
    logic [2:0] req_kind_o;
    logic [8:0] req_row_o, req_col_o;
    logic [1:0] req_be_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cyc_front dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .row_stb_n(row_stb_n),
        .col_stb_n(col_stb_n), .wr_en_n(wr_en_n), .xfer_en_n(xfer_en_n),
        .func_sel(func_sel), .req_valid_o(req_valid_o), .req_kind_o(req_kind_o),
        .req_row_o(req_row_o), .req_col_o(req_col_o), .req_be_o(req_be_o)
    );

    // {row9, col9, xfer_n, fsel, we_at_row, we_at_col, cas2, kind3, be2}
    localparam logic [28:0] VEC [8] = '{
        {9'h1A5, 9'h03C, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 3'd0, 2'b01},
        {9'h0FF, 9'h1FE, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 3'd1, 2'b10},
        {9'h123, 9'h045, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 3'd2, 2'b11},
        {9'h000, 9'h1FF, 1'b1, 1'b1, 1'b1, 1'b0, 2'b01, 3'd3, 2'b01},
        {9'h1FF, 9'h000, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 3'd3, 2'b10},
        {9'h0AA, 9'h100, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 3'd4, 2'b11},
        {9'h155, 9'h07E, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 3'd5, 2'b01},
        {9'h10F, 9'h0F0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 3'd4, 2'b10}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [28:0] v);
        logic [8:0] row, col;
        logic xn, fs, wr, wc;
        logic [1:0] cas, be;
        logic [2:0] kind;
        {row, col, xn, fs, wr, wc, cas, kind, be} = v;
        @(negedge clk);
        addr_i = row; row_stb_n = 0; xfer_en_n = xn; func_sel = fs; wr_en_n = wr;
        @(negedge clk);
        chk("R3 no pulse before column", {15'd0, req_valid_o}, 16'd0);
        // R11: flip controls after the row fall
        xfer_en_n = ~xn; func_sel = ~fs;
        addr_i = col; col_stb_n = ~cas; wr_en_n = wc;
        @(negedge clk);
        chk("R3 valid", {15'd0, req_valid_o}, 16'd1);
        chk("R5 R6 R7 R11 kind", {13'd0, req_kind_o}, {13'd0, kind});
        chk("R2 row", {7'd0, req_row_o}, {7'd0, row});
        chk("R3 column", {7'd0, req_col_o}, {7'd0, col});
        chk("R9 byte enables", {14'd0, req_be_o}, {14'd0, be});
        addr_i = ~col; col_stb_n = 2'b00;
        @(negedge clk);
        chk("R4 no second pulse", {15'd0, req_valid_o}, 16'd0);
        @(negedge clk);
        chk("R4 column held", {7'd0, req_col_o}, {7'd0, col});
        row_stb_n = 1; col_stb_n = 2'b11; xfer_en_n = 1; func_sel = 0; wr_en_n = 1;
        @(negedge clk);
        chk("R3 idle after close", {15'd0, req_valid_o}, 16'd0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {15'd0, req_valid_o}, 16'd0);
        chk("R1 fields in reset", {req_kind_o, req_row_o, req_be_o, 2'b00}, 16'd0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R1 valid after reset", {15'd0, req_valid_o}, 16'd0);
        chk("R1 column after reset", {7'd0, req_col_o}, 16'd0);

        for (int i = 0; i < 8; i++) run_vec(VEC[i]);

        // R8: option reset
        @(negedge clk);
        addr_i = 9'h0C3; col_stb_n = 2'b00; row_stb_n = 0;
        @(negedge clk);
        chk("R8 valid", {15'd0, req_valid_o}, 16'd1);
        chk("R8 kind", {13'd0, req_kind_o}, 16'd6);
        chk("R8 row", {7'd0, req_row_o}, 16'h0C3);
        chk("R8 column zero", {7'd0, req_col_o}, 16'd0);
        chk("R8 be zero", {14'd0, req_be_o}, 16'd0);
        col_stb_n = 2'b11;
        @(negedge clk);
        col_stb_n = 2'b10; addr_i = 9'h011;
        @(negedge clk);
        @(negedge clk);
        chk("R8 no later pulse", {15'd0, req_valid_o}, 16'd0);
        row_stb_n = 1; col_stb_n = 2'b11;
        @(negedge clk);

        // R10: column fall with row strobe high
        addr_i = 9'h077; col_stb_n = 2'b01;
        @(negedge clk);
        chk("R10 no pulse row high", {15'd0, req_valid_o}, 16'd0);
        @(negedge clk);
        chk("R10 still idle", {15'd0, req_valid_o}, 16'd0);
        col_stb_n = 2'b11;
        @(negedge clk);

        // R10: fresh decode on the next row fall
        addr_i = 9'h1C0; xfer_en_n = 0; func_sel = 1; row_stb_n = 0;
        @(negedge clk);
        xfer_en_n = 1; func_sel = 0; addr_i = 9'h02D; col_stb_n = 2'b10;
        @(negedge clk);
        chk("R10 fresh kind", {13'd0, req_kind_o}, 16'd5);
        chk("R10 fresh row", {7'd0, req_row_o}, 16'h1C0);
        row_stb_n = 1; col_stb_n = 2'b11;
        @(negedge clk);
        addr_i = 9'h033; row_stb_n = 0;
        @(negedge clk);
        addr_i = 9'h044; col_stb_n = 2'b01; wr_en_n = 0;
        @(negedge clk);
        chk("R10 R7 fresh write kind", {13'd0, req_kind_o}, 16'd1);
        chk("R10 fresh row 2", {7'd0, req_row_o}, 16'h033);
        row_stb_n = 1; col_stb_n = 2'b11; wr_en_n = 1;
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule